// File: doc/BRIEF.md
# Multiplexed LCD Segment and Port Driver

This block turns a 204-bit pixel image and a handful of control fields into the drive levels of a four-common, 51-segment multiplexed LCD with 1/4 duty. Each output carries a two-bit level code that stands for one of four bias rails. An analog stage outside the block turns each code into a voltage. Either 1/3 bias or 1/2 bias can be chosen. A single-cycle enable, `tick`, stands in for the oscillator. Each tick advances the scan by one half-phase. A frame has eight half-phases: each common is selected twice, first with positive and then with negative polarity, so every pixel sees zero average voltage.

A programmable prefix of the first twelve segment pins can be taken away from the display and used as plain logic outputs. The block also supports:
- display blanking;
- a power-saving mode that parks the scan but keeps the port pins alive;
- an active-low inhibit input that forces every output low at once.

The block copies the pixel image and control fields into internal registers only at the end of a frame. A change made while a frame is being scanned therefore never tears that frame.

Top module: `lcd_mux_driver`

## Requirements
- R1: Segment pin i (counting from 0) shows pixel bit `disp_data[4*i+c]` while common c (0 to 3) is selected. A set bit is lit and a clear bit is unlit.
- R2: Level codes are 0 for the ground rail, 1 for one third, 2 for two thirds and 3 for full supply. In the positive half-phase the selected common drives 3 and a lit segment drives 0; in the negative half-phase the selected common drives 0 and a lit segment drives 3. With `half_bias`=0, unselected commons drive 1 (positive) or 2 (negative), and unlit segments drive 2 (positive) or 1 (negative). With `half_bias`=1, every middle level is code 1.
- R3: Common c occupies field `com_lvl[2c+1:2c]`. The scan phase p runs from 0 to 7: p/2 is the selected common, and odd p is the negative half-phase. The phase starts at 0 and advances by one on each cycle with `tick` high. It holds when `tick` is low.
- R4: A `port_sel` value k makes segment pins 0 to k-1 into ports, and values 13 to 15 act as 12. The segment level of a port pin is 0.
- R5: Port pin i drives `disp_data[4*i]` on `port_out[i]` and drives 0 when the pin is not a port.
- R6: With `seg_blank`=1, every segment that is not a port shows the unlit level of the current half-phase. The commons keep scanning, and the port pins are unaffected.
- R7: With `pwr_save`=1, all common and segment levels are 0 and the phase is held at 0. The port pins track new data one cycle after it is applied.
- R8: With `inhibit_n`=0, every common level, segment level and port output is 0 in the same cycle.
- R9: In normal mode, the block copies its data and control inputs only at the edge where `tick` is high and the phase is 7. While power saving is in force, it copies them on every cycle.
- R10: Reset clears the phase and all held data and control fields. This gives 1/3 bias with an all-unlit display and no ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oscillator enable, one half-phase per pulse |
| inhibit_n | input | 1 | Low forces all outputs low |
| disp_data | input | 4*N_SEG | Pixel image, four bits per segment pin |
| port_sel | input | SEL_W | Number of leading segment pins used as ports |
| half_bias | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| seg_blank | input | 1 | 1 blanks the segment display |
| pwr_save | input | 1 | 1 selects power-saving mode |
| com_lvl | output | 8 | Two-bit level code per common |
| seg_lvl | output | 2*N_SEG | Two-bit level code per segment pin |
| port_out | output | N_PORT | Logic level per port-capable pin |

## Verification
The main function is swept over every `port_sel` code, including the three codes above twelve, under both bias modes. Each configuration uses a fresh random pixel image and is checked at all eight half-phases. This separates the positive and negative rail encodings, the selected common from the idle ones, and segment pins from port pins. Separate runs then:
- change data mid-frame, to show that the frame in progress keeps its old image;
- skip ticks, to show that the phase holds;
- blank the display while ports are active;
- cycle power saving while the data changes;
- drop the inhibit input, checking the outputs in the same cycle.

// File: rtl/lcd_mux_driver.sv
`timescale 1ns/1ps
module lcd_mux_driver #(
  parameter int N_SEG  = 51,
  parameter int N_PORT = 12,
  parameter int SEL_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 inhibit_n,
  input  logic [4*N_SEG-1:0]   disp_data,
  input  logic [SEL_W-1:0]     port_sel,
  input  logic                 half_bias,
  input  logic                 seg_blank,
  input  logic                 pwr_save,
  output logic [7:0]           com_lvl,
  output logic [2*N_SEG-1:0]   seg_lvl,
  output logic [N_PORT-1:0]    port_out
);
  localparam int DW    = 4 * N_SEG;
  localparam int N_COM = 4;

  logic [2:0]       phase;
  logic [DW-1:0]    sh_data;
  logic [SEL_W-1:0] sh_sel;
  logic             sh_half, sh_blank, sh_bu;

  wire frame_end = tick && (phase == 3'd7) && !sh_bu;
  wire load      = frame_end || sh_bu;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      sh_data  <= '0;
      sh_sel   <= '0;
      sh_half  <= 1'b0;
      sh_blank <= 1'b0;
      sh_bu    <= 1'b0;
    end else begin
      if (load) begin
        sh_data  <= disp_data;
        sh_sel   <= port_sel;
        sh_half  <= half_bias;
        sh_blank <= seg_blank;
        sh_bu    <= pwr_save;
      end
      if (sh_bu)     phase <= '0;
      else if (tick) phase <= phase + 3'd1;
    end
  end

  wire [1:0] cur    = phase[2:1];
  wire       neg    = phase[0];
  wire       active = inhibit_n && !sh_bu;

  wire [1:0] lv_sel  = neg ? 2'd0 : 2'd3;
  wire [1:0] lv_cmid = sh_half ? 2'd1 : (neg ? 2'd2 : 2'd1);
  wire [1:0] lv_on   = neg ? 2'd3 : 2'd0;
  wire [1:0] lv_off  = sh_half ? 2'd1 : (neg ? 2'd1 : 2'd2);

  logic [N_COM-1:0] com_full;

  for (genvar c = 0; c < N_COM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = !active ? 2'd0 :
                               (cur == 2'(c)) ? lv_sel : lv_cmid;
    assign com_full[c] = (com_lvl[2*c +: 2] == 2'd0) || (com_lvl[2*c +: 2] == 2'd3);
  end

  for (genvar i = 0; i < N_SEG; i++) begin : g_seg
    wire [3:0] pix = sh_data[4*i +: 4];
    wire [1:0] img = (sh_blank || !pix[cur]) ? lv_off : lv_on;
    if (i < N_PORT) begin : g_port
      wire is_port = (32'(sh_sel) > i);
      assign seg_lvl[2*i +: 2] = (!active || is_port) ? 2'd0 : img;
      assign port_out[i]       = inhibit_n && is_port && pix[0];

      a_r4_port_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        is_port |-> seg_lvl[2*i +: 2] == 2'd0);
      a_r5_non_port_low: assert property (@(posedge clk) disable iff (!rst_n)
        !is_port |-> !port_out[i]);
    end else begin : g_plain
      assign seg_lvl[2*i +: 2] = !active ? 2'd0 : img;
    end
  end

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sh_bu) |=> phase == $past(phase) + 3'd1);
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sh_bu) |=> $stable(phase));
  a_r7_phase_parked: assert property (@(posedge clk) disable iff (!rst_n)
    sh_bu |=> phase == 3'd0);
  a_r9_no_midframe_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_bu && !(tick && phase == 3'd7)) |=> $stable(sh_data) && $stable(sh_sel) && $stable(sh_half));
  a_r8_inhibit_low: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (com_lvl == 8'd0) && (seg_lvl == '0) && (port_out == '0));
  a_r2_one_full_common: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $countones(com_full) == 1);
  a_r7_saving_dark: assert property (@(posedge clk) disable iff (!rst_n)
    sh_bu |-> (com_lvl == 8'd0) && (seg_lvl == '0));
endmodule

// File: tb/lcd_mux_driver_test.sv
`timescale 1ns/1ps
module lcd_mux_driver_test;
  localparam int NS = 51;
  localparam int NP = 12;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, inhibit_n = 1'b1;
  logic [4*NS-1:0] d_data = '0;
  logic [3:0] d_sel = '0;
  logic d_half = 1'b0, d_blank = 1'b0, d_bu = 1'b0;
  logic [7:0] com_lvl;
  logic [2*NS-1:0] seg_lvl;
  logic [NP-1:0] port_out;

  logic [4*NS-1:0] m_data = '0;
  logic [3:0] m_sel = '0;
  logic m_half = 1'b0, m_blank = 1'b0, m_bu = 1'b0;
  int p = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_mux_driver #(.N_SEG(NS), .N_PORT(NP), .SEL_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit_n(inhibit_n),
    .disp_data(d_data), .port_sel(d_sel), .half_bias(d_half),
    .seg_blank(d_blank), .pwr_save(d_bu),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .port_out(port_out));

  task automatic model_load();
    m_data = d_data; m_sel = d_sel; m_half = d_half; m_blank = d_blank; m_bu = d_bu;
  endtask

  task automatic step(input bit t);
    bit old_bu;
    int old_p;
    tick = t;
    @(posedge clk);
    old_bu = m_bu; old_p = p;
    if ((t && old_p == 7 && !old_bu) || old_bu) model_load();
    if (old_bu) p = 0;
    else if (t) p = (old_p + 1) % 8;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic check(input string tag);
    logic [7:0] ec;
    logic [2*NS-1:0] es;
    logic [NP-1:0] ep;
    int kk, c, ng;
    logic [1:0] sel, cm, on, off;
    kk = (m_sel > NP) ? NP : int'(m_sel);
    c = p / 2; ng = p % 2;
    sel = ng ? 2'd0 : 2'd3;
    cm  = m_half ? 2'd1 : (ng ? 2'd2 : 2'd1);
    on  = ng ? 2'd3 : 2'd0;
    off = m_half ? 2'd1 : (ng ? 2'd1 : 2'd2);
    for (int j = 0; j < 4; j++) ec[2*j +: 2] = (j == c) ? sel : cm;
    for (int i = 0; i < NS; i++)
      es[2*i +: 2] = (i < kk) ? 2'd0 : ((m_blank || !m_data[4*i+c]) ? off : on);
    for (int i = 0; i < NP; i++) ep[i] = (i < kk) ? m_data[4*i] : 1'b0;
    if (m_bu) begin ec = '0; es = '0; end
    if (!inhibit_n) begin ec = '0; es = '0; ep = '0; end
    total += 3;
    if (com_lvl !== ec) begin bad++; $display("FAIL %s com_lvl actual=%h expected=%h", tag, com_lvl, ec); end
    if (seg_lvl !== es) begin bad++; $display("FAIL %s seg_lvl actual=%h expected=%h", tag, seg_lvl, es); end
    if (port_out !== ep) begin bad++; $display("FAIL %s port_out actual=%h expected=%h", tag, port_out, ep); end
  endtask

  task automatic randomize_data();
    for (int j = 0; j < 4*NS; j++) d_data[j] = 1'($urandom_range(0, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (com_lvl !== 8'b01_01_01_11 || port_out !== '0) begin
      bad++; $display("FAIL R10 reset com=%h port=%h expected com=57 port=0", com_lvl, port_out);
    end
    check("R10");

    for (int dr = 0; dr < 2; dr++)
      for (int k = 0; k < 16; k++) begin
        randomize_data();
        d_sel = 4'(k); d_half = 1'(dr);
        for (int s = 0; s < 16; s++) begin
          step(1'b1);
          check("R1 R2 R3 R4 R5");
        end
      end

    d_sel = 4'd3; d_half = 1'b0;
    repeat (8) step(1'b1);
    repeat (3) step(1'b1);
    randomize_data(); d_sel = 4'd9;
    for (int s = 0; s < 8; s++) begin step(1'b1); check("R9"); end

    for (int s = 0; s < 4; s++) begin step(1'b0); check("R3 hold"); end
    step(1'b1); check("R3");

    while (p != 0) step(1'b1);
    d_blank = 1'b1; d_sel = 4'd5; randomize_data();
    for (int s = 0; s < 16; s++) begin step(1'b1); check("R6"); end

    d_blank = 1'b0; d_bu = 1'b1; d_sel = 4'd12;
    for (int s = 0; s < 10; s++) begin step(1'b1); check("R7"); end
    for (int s = 0; s < 4; s++) begin
      randomize_data(); step(s % 2 == 1); check("R7 ports");
    end
    d_bu = 1'b0;
    for (int s = 0; s < 10; s++) begin step(1'b1); check("R7 exit"); end

    inhibit_n = 1'b0; #1; check("R8");
    for (int s = 0; s < 5; s++) begin step(1'b1); check("R8"); end
    inhibit_n = 1'b1; #1; check("R8 release");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule